// File: doc/BRIEF.md
# SBC Operating Mode Controller

This block is the mode sequencer of a system basis controller. It holds the current operating mode (Reset, Normal Request, Normal, Standby, Stop or Sleep) and turns it into the control levels that the rest of the chip uses: the enable and low-power select of the main regulator, the enable of the secondary regulator, the watchdog run enable, the CAN transceiver enables and the oscillator select. The analog regulators, the oscillators and the serial register shifter sit outside the block.

Software changes the mode by writing a mode command through a one-cycle register write strobe. Commands that the current mode does not accept are dropped and the mode is kept. A wake event brings the block out of the low-power modes, a supply fault or a watchdog expiry forces the Reset mode, and the Reset mode always passes through a timed hold followed by the transient Normal Request mode. In Normal Request software must confirm Normal or Standby.

Each control output is decoded from the state register alone, so every output changes in the same cycle as `mode_code`. An input sampled at a clock edge moves the state at that same edge.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in Reset (`mode_code` 0) with `sys_rst_n` low, stays there for exactly `RST_CYCLES` cycles, and then enters Normal Request (`mode_code` 1).
- R2: `fault_rst` high at a clock edge in any mode except Sleep puts the block in Reset at that edge; in Reset it restarts the full `RST_CYCLES` hold.
- R3: In Normal Request a valid command code 1 selects Normal (`mode_code` 2) and code 2 selects Standby (`mode_code` 3); codes 3 (Stop) and 4 (Sleep) are ignored.
- R4: In Normal and Standby, valid command codes 1, 2, 3 and 4 select Normal, Standby, Stop (`mode_code` 4) and Sleep (`mode_code` 5); a command for the current mode keeps it.
- R5: `wdt_expired` high moves Normal Request, Normal and Standby to Reset; it is ignored in Reset, Stop and Sleep.
- R6: In Stop, `wake_evt` moves the block to Normal Request; all commands are ignored in Stop.
- R7: In Sleep, `wake_evt` moves the block to Reset; commands, `fault_rst` and `wdt_expired` are ignored in Sleep.
- R8: When inputs coincide, `fault_rst` wins over `wdt_expired`, which wins over `wake_evt`, which wins over a command.
- R9: Command codes 0, 5, 6 and 7, and any code presented with `cmd_valid` low, never change the mode; `wake_evt` is ignored outside Stop and Sleep.
- R10: Regulator outputs per mode: `reg1_en` is high in every mode except Sleep; `reg1_low_pwr` is high only in Stop; `reg2_en` is high only in Normal Request and Normal.
- R11: `wdt_run` is high only in Normal Request, Normal and Standby; `can_active` is high only in Normal; `can_wake_en` is high only in Standby, Stop and Sleep; `sys_rst_n` is low only in Reset.
- R12: `osc_hi_acc` is high in Reset, Normal Request, Normal and Standby and low in Stop and Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe of a mode command write |
| cmd_code | input | 3 | Requested mode: 1 Normal, 2 Standby, 3 Stop, 4 Sleep |
| wake_evt | input | 1 | Wake event from bus or wake inputs |
| fault_rst | input | 1 | Reset condition such as main supply undervoltage |
| wdt_expired | input | 1 | Watchdog timeout indication |
| mode_code | output | 3 | Current mode: 0 Reset, 1 Normal Request, 2 Normal, 3 Standby, 4 Stop, 5 Sleep |
| sys_rst_n | output | 1 | Active-low reset to the host |
| reg1_en | output | 1 | Main regulator enable |
| reg1_low_pwr | output | 1 | Main regulator low-power select |
| reg2_en | output | 1 | Secondary regulator enable |
| wdt_run | output | 1 | Watchdog run enable |
| can_active | output | 1 | CAN transceiver communication enable |
| can_wake_en | output | 1 | CAN wake receiver enable |
| osc_hi_acc | output | 1 | High-accuracy oscillator select |

## Verification
The bench builds the block with `RST_CYCLES` set to 5, short enough that many Reset holds, including one restarted by a fault halfway through, fit in a short run, and long enough that an off-by-one in the hold counter shows as a mode change one cycle early or late. A behavioural model of the mode rules is compared with the mode and every control output on each clock. The stimulus walks every legal and illegal command from each mode, and it drives coincident fault, watchdog, wake and command inputs to exercise the priority order.

// File: rtl/sbc_mode_pkg.sv
// Shared types for the mode controller.
// Assumes: mode and command encodings below are visible to software and fixed.
package sbc_mode_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_NREQ    = 3'd1,
        ST_NORMAL  = 3'd2,
        ST_STANDBY = 3'd3,
        ST_STOP    = 3'd4,
        ST_SLEEP   = 3'd5
    } sbc_state_e;

    localparam logic [2:0] CMD_NORMAL  = 3'd1;
    localparam logic [2:0] CMD_STANDBY = 3'd2;
    localparam logic [2:0] CMD_STOP    = 3'd3;
    localparam logic [2:0] CMD_SLEEP   = 3'd4;

    typedef struct packed {
        logic rst_n;
        logic reg1_on;
        logic reg1_lp;
        logic reg2_on;
        logic wd_run;
        logic can_act;
        logic can_wake;
        logic osc_hi;
    } sbc_ctrl_t;

endpackage

// File: rtl/sbc_mode_hold_timer.sv
// Counts the length of the Reset hold.
// Reloads while the mode is not Reset or a reload is requested, counts down
// otherwise; done is high on the last hold cycle.
// Assumes: HOLD_CYCLES >= 2.
module sbc_mode_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Reload or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    p_hold_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);

    p_hold_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/sbc_mode_next.sv
// Next-mode decision for the controller.
// Applies the priority fault > watchdog > wake > command and the per-mode
// acceptance rules; unaccepted commands leave the mode unchanged.
// Assumes: hold_done comes from the Reset hold timer.
module sbc_mode_next
    import sbc_mode_pkg::*;
(
    input  sbc_state_e cur,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       wake_evt,
    input  logic       fault_rst,
    input  logic       wdt_expired,
    input  logic       hold_done,
    output sbc_state_e nxt
);
    logic       cmd_run;
    sbc_state_e cmd_tgt;

    // Map a command code to a target mode and flag whether it is a known code
    always_comb begin
        cmd_run = cmd_valid;
        cmd_tgt = cur;
        unique case (cmd_code)
            CMD_NORMAL:  cmd_tgt = ST_NORMAL;
            CMD_STANDBY: cmd_tgt = ST_STANDBY;
            CMD_STOP:    cmd_tgt = ST_STOP;
            CMD_SLEEP:   cmd_tgt = ST_SLEEP;
            default:     cmd_run = 1'b0;
        endcase
    end

    // Per-mode transition rules
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_RESET: begin
                if (!fault_rst && hold_done) nxt = ST_NREQ;
            end
            ST_NREQ: begin
                if (fault_rst || wdt_expired) nxt = ST_RESET;
                else if (cmd_run && (cmd_tgt == ST_NORMAL || cmd_tgt == ST_STANDBY))
                    nxt = cmd_tgt;
            end
            ST_NORMAL, ST_STANDBY: begin
                if (fault_rst || wdt_expired) nxt = ST_RESET;
                else if (cmd_run) nxt = cmd_tgt;
            end
            ST_STOP: begin
                if (fault_rst) nxt = ST_RESET;
                else if (wake_evt) nxt = ST_NREQ;
            end
            ST_SLEEP: begin
                if (wake_evt) nxt = ST_RESET;
            end
            default: nxt = ST_RESET;
        endcase
    end

endmodule

// File: rtl/sbc_mode_outmap.sv
// Decodes the mode into regulator, watchdog, CAN and oscillator controls.
// Assumes: purely combinational, so outputs follow the state register.
module sbc_mode_outmap
    import sbc_mode_pkg::*;
(
    input  sbc_state_e cur,
    output sbc_ctrl_t  ctrl
);
    // One control word per mode
    always_comb begin
        unique case (cur)
            ST_RESET:   ctrl = '{rst_n:1'b0, reg1_on:1'b1, reg1_lp:1'b0, reg2_on:1'b0,
                                 wd_run:1'b0, can_act:1'b0, can_wake:1'b0, osc_hi:1'b1};
            ST_NREQ:    ctrl = '{rst_n:1'b1, reg1_on:1'b1, reg1_lp:1'b0, reg2_on:1'b1,
                                 wd_run:1'b1, can_act:1'b0, can_wake:1'b0, osc_hi:1'b1};
            ST_NORMAL:  ctrl = '{rst_n:1'b1, reg1_on:1'b1, reg1_lp:1'b0, reg2_on:1'b1,
                                 wd_run:1'b1, can_act:1'b1, can_wake:1'b0, osc_hi:1'b1};
            ST_STANDBY: ctrl = '{rst_n:1'b1, reg1_on:1'b1, reg1_lp:1'b0, reg2_on:1'b0,
                                 wd_run:1'b1, can_act:1'b0, can_wake:1'b1, osc_hi:1'b1};
            ST_STOP:    ctrl = '{rst_n:1'b1, reg1_on:1'b1, reg1_lp:1'b1, reg2_on:1'b0,
                                 wd_run:1'b0, can_act:1'b0, can_wake:1'b1, osc_hi:1'b0};
            ST_SLEEP:   ctrl = '{rst_n:1'b1, reg1_on:1'b0, reg1_lp:1'b0, reg2_on:1'b0,
                                 wd_run:1'b0, can_act:1'b0, can_wake:1'b1, osc_hi:1'b0};
            default:    ctrl = '{rst_n:1'b0, reg1_on:1'b1, reg1_lp:1'b0, reg2_on:1'b0,
                                 wd_run:1'b0, can_act:1'b0, can_wake:1'b0, osc_hi:1'b1};
        endcase
    end

endmodule

// File: rtl/sbc_mode_ctrl.sv
// Operating mode controller of a system basis controller.
// Holds the mode register, times the Reset hold and drives the supply,
// watchdog, CAN and oscillator controls from the mode.
// Assumes: all inputs are synchronous to clk; cmd_valid is a one-cycle strobe.
module sbc_mode_ctrl
    import sbc_mode_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       wake_evt,
    input  logic       fault_rst,
    input  logic       wdt_expired,
    output logic [2:0] mode_code,
    output logic       sys_rst_n,
    output logic       reg1_en,
    output logic       reg1_low_pwr,
    output logic       reg2_en,
    output logic       wdt_run,
    output logic       can_active,
    output logic       can_wake_en,
    output logic       osc_hi_acc
);
    sbc_state_e state_q, state_d;
    sbc_ctrl_t  ctrl;
    logic       hold_done;
    logic       hold_reload;

    // Reload the hold outside Reset and on a fault inside it
    assign hold_reload = (state_q != ST_RESET) || fault_rst;

    sbc_mode_hold_timer #(.HOLD_CYCLES(RST_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (hold_reload),
        .done   (hold_done)
    );

    sbc_mode_next u_next (
        .cur         (state_q),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .wake_evt    (wake_evt),
        .fault_rst   (fault_rst),
        .wdt_expired (wdt_expired),
        .hold_done   (hold_done),
        .nxt         (state_d)
    );

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    sbc_mode_outmap u_map (
        .cur  (state_q),
        .ctrl (ctrl)
    );

    assign mode_code    = state_q;
    assign sys_rst_n    = ctrl.rst_n;
    assign reg1_en      = ctrl.reg1_on;
    assign reg1_low_pwr = ctrl.reg1_lp;
    assign reg2_en      = ctrl.reg2_on;
    assign wdt_run      = ctrl.wd_run;
    assign can_active   = ctrl.can_act;
    assign can_wake_en  = ctrl.can_wake;
    assign osc_hi_acc   = ctrl.osc_hi;

    p_nreq_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_NREQ && state_q != ST_NREQ) |->
            (state_q == ST_RESET || state_q == ST_STOP));

    p_wdt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expired && (state_q == ST_NREQ || state_q == ST_NORMAL || state_q == ST_STANDBY))
            |=> (mode_code == 3'd0));

    p_stop_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && wake_evt && !fault_rst) |=> (mode_code == 3'd1));

    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !wake_evt) |=> (mode_code == 3'd5));

    p_reg2_needs_reg1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg2_en |-> (reg1_en && !reg1_low_pwr));

    p_can_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(can_active && can_wake_en));

    p_rst_no_wd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> !wdt_run);

    p_lowosc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_hi_acc |-> (!wdt_run && !reg2_en));

endmodule

// File: tb/sbc_mode_ctrl_bench.sv
module sbc_mode_ctrl_bench;
    localparam int RC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_valid = 1'b0;
    logic [2:0] b_code = 3'd0;
    logic       b_wake = 1'b0;
    logic       b_fault = 1'b0;
    logic       b_wdt = 1'b0;

    logic [2:0] mode_code;
    logic sys_rst_n, reg1_en, reg1_low_pwr, reg2_en, wdt_run;
    logic can_active, can_wake_en, osc_hi_acc;

    sbc_mode_ctrl #(.RST_CYCLES(RC)) u_sbc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(b_valid), .cmd_code(b_code),
        .wake_evt(b_wake), .fault_rst(b_fault), .wdt_expired(b_wdt),
        .mode_code(mode_code), .sys_rst_n(sys_rst_n), .reg1_en(reg1_en),
        .reg1_low_pwr(reg1_low_pwr), .reg2_en(reg2_en), .wdt_run(wdt_run),
        .can_active(can_active), .can_wake_en(can_wake_en), .osc_hi_acc(osc_hi_acc)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string tag = "R1";

    int ms = 0;
    int mleft = RC;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Expected control word {rst_n, reg1, reg1_lp, reg2, wd, can, canwake, osc}
    function automatic logic [7:0] exp_ctrl(input int st);
        case (st)
            0: return 8'b0100_0001;
            1: return 8'b1101_1001;
            2: return 8'b1101_1101;
            3: return 8'b1100_1011;
            4: return 8'b1110_0010;
            5: return 8'b1000_0010;
            default: return 8'hxx;
        endcase
    endfunction

    // Behavioural reference of the mode rules
    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            ms = 0; mleft = RC; armed = 1;
        end else begin
            nx = ms;
            case (ms)
                0: if (b_fault) mleft = RC;
                   else if (mleft == 1) nx = 1;
                   else mleft = mleft - 1;
                1: if (b_fault || b_wdt) nx = 0;
                   else if (b_valid && (b_code == 1 || b_code == 2)) nx = b_code + 1;
                2, 3: if (b_fault || b_wdt) nx = 0;
                   else if (b_valid && b_code >= 1 && b_code <= 4) nx = b_code + 1;
                4: if (b_fault) nx = 0;
                   else if (b_wake) nx = 1;
                5: if (b_wake) nx = 0;
                default: nx = 0;
            endcase
            if (nx == 0 && ms != 0) mleft = RC;
            ms = nx;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        logic [7:0] e, a;
        if (armed && !done) begin
            e = exp_ctrl(ms);
            a = {sys_rst_n, reg1_en, reg1_low_pwr, reg2_en, wdt_run, can_active,
                 can_wake_en, osc_hi_acc};
            check(mode_code == 3'(ms), tag, mode_code, ms);
            check(a[7] == e[7], "R1", a[7], e[7]);
            check(a[6:4] == e[6:4], "R10", a[6:4], e[6:4]);
            check(a[3:1] == e[3:1], "R11", a[3:1], e[3:1]);
            check(a[0] == e[0], "R12", a[0], e[0]);
        end
    end

    task automatic cyc(input bit v, input logic [2:0] c, input bit w, input bit f, input bit t);
        @(negedge clk);
        #1;
        b_valid = v; b_code = c; b_wake = w; b_fault = f; b_wdt = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog for a hung run
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(RC + 2);
        check(mode_code == 3'd1, "R1", mode_code, 1);

        tag = "R9";
        cyc(0, 3'd1, 0, 0, 0);
        cyc(1, 3'd0, 0, 0, 0); cyc(1, 3'd5, 0, 0, 0);
        cyc(1, 3'd6, 0, 0, 0); cyc(1, 3'd7, 0, 0, 0);
        cyc(0, 3'd0, 1, 0, 0); idle(1);

        tag = "R3";
        cyc(1, 3'd3, 0, 0, 0); cyc(1, 3'd4, 0, 0, 0);
        cyc(1, 3'd1, 0, 0, 0); idle(1);
        check(mode_code == 3'd2, "R3", mode_code, 2);

        tag = "R4";
        cyc(1, 3'd1, 0, 0, 0); cyc(1, 3'd2, 0, 0, 0);
        cyc(1, 3'd2, 0, 0, 0); cyc(1, 3'd1, 0, 0, 0);
        cyc(1, 3'd2, 0, 0, 0); idle(1);
        tag = "R9";
        cyc(0, 3'd0, 1, 0, 0); cyc(1, 3'd7, 0, 0, 0); idle(1);

        tag = "R5";
        cyc(0, 3'd0, 0, 0, 1); idle(1);
        check(mode_code == 3'd0, "R5", mode_code, 0);
        cyc(0, 3'd0, 0, 0, 1); idle(RC + 1);
        cyc(0, 3'd0, 0, 0, 1); idle(RC + 1);
        cyc(1, 3'd1, 0, 0, 0); cyc(0, 3'd0, 0, 0, 1); idle(RC + 1);

        tag = "R6";
        cyc(1, 3'd1, 0, 0, 0); cyc(1, 3'd3, 0, 0, 0); idle(1);
        check(mode_code == 3'd4, "R4", mode_code, 4);
        cyc(1, 3'd1, 0, 0, 0); cyc(1, 3'd2, 0, 0, 0);
        cyc(0, 3'd0, 0, 0, 1); idle(1);
        cyc(0, 3'd0, 1, 0, 0); idle(1);
        check(mode_code == 3'd1, "R6", mode_code, 1);

        tag = "R7";
        cyc(1, 3'd2, 0, 0, 0); cyc(1, 3'd4, 0, 0, 0); idle(1);
        cyc(1, 3'd1, 0, 0, 0); cyc(0, 3'd0, 0, 1, 0);
        cyc(0, 3'd0, 0, 0, 1); idle(2);
        check(mode_code == 3'd5, "R7", mode_code, 5);
        cyc(0, 3'd0, 1, 0, 0); idle(1);
        check(mode_code == 3'd0, "R7", mode_code, 0);
        idle(RC + 1);

        tag = "R2";
        cyc(1, 3'd1, 0, 0, 0); cyc(0, 3'd0, 0, 1, 0); idle(2);
        cyc(0, 3'd0, 0, 1, 0); idle(RC - 1);
        check(mode_code == 3'd0, "R2", mode_code, 0);
        idle(2);
        cyc(1, 3'd2, 0, 0, 0); cyc(0, 3'd0, 0, 1, 0); idle(RC + 1);

        tag = "R8";
        cyc(1, 3'd1, 0, 0, 0);
        cyc(1, 3'd3, 1, 1, 1); idle(RC + 1);
        cyc(1, 3'd1, 0, 0, 0); cyc(1, 3'd3, 0, 0, 0);
        cyc(1, 3'd1, 1, 0, 1); idle(1);
        check(mode_code == 3'd1, "R8", mode_code, 1);
        cyc(1, 3'd1, 0, 0, 0); cyc(1, 3'd3, 0, 0, 0);
        cyc(0, 3'd0, 1, 1, 0); idle(1);
        check(mode_code == 3'd0, "R8", mode_code, 0);
        idle(RC + 1);
        cyc(1, 3'd1, 1, 0, 1); idle(2);
        cyc(1, 3'd2, 0, 0, 0); cyc(1, 3'd1, 1, 0, 0); idle(2);

        finish_run();
    end
endmodule